// File: doc/BRIEF.md
# Instruction Cell Cache Controller

This block manages a group of instruction cells that together cache the instructions belonging to one major address. For every cell it keeps a table entry holding the minor address the cell serves and a status: free, engaged or occupied. An engaged cell has been claimed and is waiting for its instruction to come back from instruction memory. An occupied cell holds its instruction. A recency ordering of the cells decides which occupied cell gives up its contents when a new instruction needs a home.

Fetches are started by operand traffic, not by instruction fetch. When a data or control packet arrives for a minor address that has no cell, the block claims a cell for it and sends a retrieve command. If it has to, it first evicts a resident instruction: it names the cell whose contents must be shipped out, and one cycle later it issues a store command. The surrounding datapath applies the operand update to the named cell. That datapath reports per cell when every register is enabled, and the block then announces the firing. It reports an instruction packet that nobody is waiting for.

At most one data packet, one instruction packet and one firing are handled per cycle. The outputs are registered one cycle after the inputs that cause them, except the store command (two cycles) and the combinational acceptance flag.

Top module: `icell_cache_ctl`

## Requirements
- R1: After reset all cells are free, every output pulse is low and `pkt_accept` is high.
- R2: A packet whose minor address matches an engaged or occupied cell produces `upd_valid` with that cell index on the next cycle, and no retrieve command, so an engaged cell is never fetched twice.
- R3: A packet that misses while a free cell exists claims the lowest-numbered free cell. On the next cycle it gives `upd_valid`/`upd_cell` for that cell and `retr_valid` with the packet's minor address, with no eviction.
- R4: A packet that misses with no free cell evicts the chosen occupied cell. On the next cycle `evict_valid`, `evict_cell` and `evict_minor` (the old minor address) appear together with the retrieve for the new address. On the cycle after that, `store_valid` carries the old minor address.
- R5: When a packet misses and no cell is free or evictable, `pkt_accept` is low in the same cycle and the packet causes no output and no table change.
- R6: An instruction packet whose minor address matches an engaged cell makes that cell occupied and gives `load_valid`/`load_cell` on the next cycle.
- R7: An instruction packet matching no engaged cell gives a one-cycle `orphan_err` on the next cycle and no load.
- R8: An occupied cell whose `cell_ready` bit is high fires: `fire_valid`/`fire_cell` appear on the next cycle, with the lowest index first when several are ready. Engaged or free cells never fire.
- R9: The eviction victim is the occupied cell used least recently. A cell counts as used when it is claimed, loaded or fired. At reset the order runs from cell 0 (first victim) to the highest cell.
- R10: A cell that fires in the same cycle as a miss is never chosen as that miss's victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Data or control packet present |
| pkt_minor | input | MINW | Minor address of that packet |
| pkt_accept | output | 1 | Packet can be taken this cycle |
| ipkt_valid | input | 1 | Instruction packet returned from memory |
| ipkt_minor | input | MINW | Minor address of the instruction packet |
| cell_ready | input | N | Per cell: all registers enabled |
| upd_valid | output | 1 | Apply the operand update |
| upd_cell | output | IW | Cell receiving the update |
| retr_valid | output | 1 | Retrieve command |
| retr_minor | output | MINW | Minor address to retrieve |
| evict_valid | output | 1 | Ship a cell's contents to memory |
| evict_cell | output | IW | Cell being evicted |
| evict_minor | output | MINW | Minor address of the evicted instruction |
| store_valid | output | 1 | Store command |
| store_minor | output | MINW | Minor address to store |
| load_valid | output | 1 | Write the returned instruction into a cell |
| load_cell | output | IW | Cell being loaded |
| fire_valid | output | 1 | A cell fires; reset its operands |
| fire_cell | output | IW | Firing cell |
| orphan_err | output | 1 | Instruction packet with no engaged entry |

## Verification
A firing and a miss that needs an eviction can fall in the same cycle. The recency order alone would then pick the firing cell as the victim. The bench arranges this by raising the ready bit of the least recently used occupied cell in the same cycle as a missing packet. It passes if the firing is reported and the eviction names the next candidate in recency order. A second overlap exists between an instruction packet loading an engaged cell and a packet arriving for that same engaged cell. This case is judged by the later behaviour of the cell: it is hit without a second retrieve, and once loaded it can be evicted.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_ENG  = 2'd1,
        ST_OCC  = 2'd2
    } cell_st_e;
endpackage

// File: rtl/cc_first.sv
module cc_first #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cc_lookup.sv
module cc_lookup #(
    parameter int N    = 4,
    parameter int MINW = 8,
    parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][MINW-1:0] tab,
    input  logic [N-1:0]           cand,
    input  logic [MINW-1:0]        key,
    output logic                   hit,
    output logic [IW-1:0]          idx
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = cand[g] && (tab[g] == key);
    end

    cc_first #(.N(N), .IW(IW)) u_pick (.req(eq), .found(hit), .idx(idx));
endmodule

// File: rtl/cc_lru.sv
module cc_lru #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  elig,
    input  logic          mv_a_en,
    input  logic [IW-1:0] mv_a,
    input  logic          mv_b_en,
    input  logic [IW-1:0] mv_b,
    input  logic          mv_c_en,
    input  logic [IW-1:0] mv_c,
    output logic          vic_found,
    output logic [IW-1:0] vic_idx
);
    typedef logic [N-1:0][IW-1:0] ord_t;

    ord_t order_d, order_q;

    function automatic ord_t to_back(input ord_t o, input logic [IW-1:0] c);
        ord_t r;
        int   j;
        r = o;
        j = 0;
        for (int k = 0; k < N; k++) begin
            if (o[k] != c) begin
                r[j] = o[k];
                j++;
            end
        end
        r[N-1] = c;
        return r;
    endfunction

    always_comb begin
        vic_found = 1'b0;
        vic_idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (elig[order_q[k]]) begin
                vic_found = 1'b1;
                vic_idx   = order_q[k];
            end
        end
        order_d = order_q;
        if (mv_a_en) order_d = to_back(order_d, mv_a);
        if (mv_b_en) order_d = to_back(order_d, mv_b);
        if (mv_c_en) order_d = to_back(order_d, mv_c);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) order_q[i] <= IW'(i);
        end else begin
            order_q <= order_d;
        end
    end

    logic [N-1:0] seen;
    always_comb begin
        seen = '0;
        for (int k = 0; k < N; k++) seen[order_q[k]] = 1'b1;
    end

    // R9
    perm_chk: assert property (@(posedge clk) disable iff (!rst_n) (&seen));
endmodule

// File: rtl/icell_cache_ctl.sv
module icell_cache_ctl #(
    parameter int N    = 4,
    parameter int MINW = 8,
    parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pkt_valid,
    input  logic [MINW-1:0] pkt_minor,
    output logic            pkt_accept,
    input  logic            ipkt_valid,
    input  logic [MINW-1:0] ipkt_minor,
    input  logic [N-1:0]    cell_ready,
    output logic            upd_valid,
    output logic [IW-1:0]   upd_cell,
    output logic            retr_valid,
    output logic [MINW-1:0] retr_minor,
    output logic            evict_valid,
    output logic [IW-1:0]   evict_cell,
    output logic [MINW-1:0] evict_minor,
    output logic            store_valid,
    output logic [MINW-1:0] store_minor,
    output logic            load_valid,
    output logic [IW-1:0]   load_cell,
    output logic            fire_valid,
    output logic [IW-1:0]   fire_cell,
    output logic            orphan_err
);
    import cc_pkg::*;

    typedef struct packed {
        logic [N-1:0][MINW-1:0] minor;
        cell_st_e [N-1:0]       st;
        logic                   upd_valid;
        logic [IW-1:0]          upd_cell;
        logic                   retr_valid;
        logic [MINW-1:0]        retr_minor;
        logic                   evict_valid;
        logic [IW-1:0]          evict_cell;
        logic [MINW-1:0]        evict_minor;
        logic                   store_valid;
        logic [MINW-1:0]        store_minor;
        logic                   load_valid;
        logic [IW-1:0]          load_cell;
        logic                   fire_valid;
        logic [IW-1:0]          fire_cell;
        logic                   orphan_err;
    } state_t;

    state_t s_d, s_q;

    logic [N-1:0] occ_vec, eng_vec, free_vec, live_vec, elig_vec;
    logic [N-1:0] fire_mask;
    logic         fire_any, d_hit, fr_any, i_hit, vic_found;
    logic [IW-1:0] fire_idx, d_idx, fr_idx, i_idx, vic_idx, alloc_idx;
    logic         do_alloc, do_evict, do_load;

    for (genvar g = 0; g < N; g++) begin : g_stat
        assign occ_vec[g]  = (s_q.st[g] == ST_OCC);
        assign eng_vec[g]  = (s_q.st[g] == ST_ENG);
        assign free_vec[g] = (s_q.st[g] == ST_FREE);
    end
    assign live_vec = occ_vec | eng_vec;

    cc_first #(.N(N), .IW(IW)) u_fire (
        .req(occ_vec & cell_ready), .found(fire_any), .idx(fire_idx));
    cc_first #(.N(N), .IW(IW)) u_free (
        .req(free_vec), .found(fr_any), .idx(fr_idx));
    cc_lookup #(.N(N), .MINW(MINW), .IW(IW)) u_dlook (
        .tab(s_q.minor), .cand(live_vec), .key(pkt_minor), .hit(d_hit), .idx(d_idx));
    cc_lookup #(.N(N), .MINW(MINW), .IW(IW)) u_ilook (
        .tab(s_q.minor), .cand(eng_vec), .key(ipkt_minor), .hit(i_hit), .idx(i_idx));

    assign fire_mask = fire_any ? (N'(1) << fire_idx) : '0;
    assign elig_vec  = occ_vec & ~fire_mask;

    assign pkt_accept = d_hit | fr_any | vic_found;
    assign do_alloc   = pkt_valid && !d_hit && (fr_any || vic_found);
    assign do_evict   = do_alloc && !fr_any;
    assign alloc_idx  = fr_any ? fr_idx : vic_idx;
    assign do_load    = ipkt_valid && i_hit;

    cc_lru #(.N(N), .IW(IW)) u_lru (
        .clk(clk), .rst_n(rst_n), .elig(elig_vec),
        .mv_a_en(fire_any), .mv_a(fire_idx),
        .mv_b_en(do_alloc), .mv_b(alloc_idx),
        .mv_c_en(do_load),  .mv_c(i_idx),
        .vic_found(vic_found), .vic_idx(vic_idx));

    always_comb begin
        s_d             = s_q;
        s_d.upd_valid   = 1'b0;
        s_d.retr_valid  = 1'b0;
        s_d.evict_valid = 1'b0;
        s_d.load_valid  = 1'b0;
        s_d.fire_valid  = 1'b0;
        s_d.orphan_err  = 1'b0;
        s_d.store_valid = s_q.evict_valid;
        s_d.store_minor = s_q.evict_minor;

        if (pkt_valid && pkt_accept) begin
            s_d.upd_valid = 1'b1;
            s_d.upd_cell  = d_hit ? d_idx : alloc_idx;
        end
        if (do_alloc) begin
            if (do_evict) begin
                s_d.evict_valid = 1'b1;
                s_d.evict_cell  = alloc_idx;
                s_d.evict_minor = s_q.minor[alloc_idx];
            end
            s_d.st[alloc_idx]    = ST_ENG;
            s_d.minor[alloc_idx] = pkt_minor;
            s_d.retr_valid       = 1'b1;
            s_d.retr_minor       = pkt_minor;
        end
        if (ipkt_valid) begin
            if (i_hit) begin
                s_d.st[i_idx]  = ST_OCC;
                s_d.load_valid = 1'b1;
                s_d.load_cell  = i_idx;
            end else begin
                s_d.orphan_err = 1'b1;
            end
        end
        if (fire_any) begin
            s_d.fire_valid = 1'b1;
            s_d.fire_cell  = fire_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign upd_valid   = s_q.upd_valid;
    assign upd_cell    = s_q.upd_cell;
    assign retr_valid  = s_q.retr_valid;
    assign retr_minor  = s_q.retr_minor;
    assign evict_valid = s_q.evict_valid;
    assign evict_cell  = s_q.evict_cell;
    assign evict_minor = s_q.evict_minor;
    assign store_valid = s_q.store_valid;
    assign store_minor = s_q.store_minor;
    assign load_valid  = s_q.load_valid;
    assign load_cell   = s_q.load_cell;
    assign fire_valid  = s_q.fire_valid;
    assign fire_cell   = s_q.fire_cell;
    assign orphan_err  = s_q.orphan_err;

    // R3
    retr_has_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retr_valid |-> upd_valid);
    // R4
    evict_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (retr_valid && retr_minor != evict_minor && upd_cell == evict_cell));
    // R5
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_accept && !ipkt_valid) |=> (!upd_valid && !retr_valid && !evict_valid));
    // R7
    err_load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(orphan_err && load_valid));
    // R8
    fire_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid |-> (($past(occ_vec) & (N'(1) << fire_cell)) != '0));
    // R10
    no_self_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_valid && evict_valid) |-> (fire_cell != evict_cell));
endmodule

// File: tb/sim_icell_cache_ctl.sv
`timescale 1ns/100ps
module sim_icell_cache_ctl;
    localparam int N = 4, MINW = 8, IW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pkt_valid = 1'b0, ipkt_valid = 1'b0;
    logic [MINW-1:0] pkt_minor = '0, ipkt_minor = '0;
    logic [N-1:0] cell_ready = '0;
    logic pkt_accept, upd_valid, retr_valid, evict_valid, store_valid;
    logic load_valid, fire_valid, orphan_err;
    logic [IW-1:0] upd_cell, evict_cell, load_cell, fire_cell;
    logic [MINW-1:0] retr_minor, evict_minor, store_minor;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    icell_cache_ctl #(.N(N), .MINW(MINW)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one packet, outputs checked one cycle later
    task automatic send(input logic [MINW-1:0] m);
        @(negedge clk); pkt_valid = 1'b1; pkt_minor = m;
        @(negedge clk); pkt_valid = 1'b0;
    endtask

    task automatic send_ins(input logic [MINW-1:0] m);
        @(negedge clk); ipkt_valid = 1'b1; ipkt_minor = m;
        @(negedge clk); ipkt_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 upd", upd_valid, 0);
        chk("R1 retr", retr_valid, 0);
        chk("R1 evict", evict_valid, 0);
        chk("R1 fire", fire_valid, 0);
        chk("R1 err", orphan_err, 0);
        chk("R1 accept", pkt_accept, 1);
    endtask

    task automatic t_fill();
        send(8'h10);
        chk("R3 upd", upd_valid, 1); chk("R3 cell", upd_cell, 0);
        chk("R3 retr", retr_valid, 1); chk("R3 minor", retr_minor, 8'h10);
        chk("R3 noevict", evict_valid, 0);
        send(8'h10);
        chk("R2 upd", upd_valid, 1); chk("R2 cell", upd_cell, 0);
        chk("R2 no second retr", retr_valid, 0);
        send(8'h20); chk("R3 cell1", upd_cell, 1);
        send(8'h30); chk("R3 cell2", upd_cell, 2);
        send(8'h40); chk("R3 cell3", upd_cell, 3); chk("R3 retr40", retr_minor, 8'h40);
    endtask

    task automatic t_orphan();
        send_ins(8'h55);
        chk("R7 err", orphan_err, 1); chk("R7 noload", load_valid, 0);
        @(negedge clk); chk("R7 pulse", orphan_err, 0);
    endtask

    task automatic t_load();
        send_ins(8'h10); chk("R6 load", load_valid, 1); chk("R6 cell0", load_cell, 0);
        send_ins(8'h20); chk("R6 cell1", load_cell, 1);
        send_ins(8'h30); chk("R6 cell2", load_cell, 2);
        send_ins(8'h40); chk("R6 cell3", load_cell, 3); chk("R6 noerr", orphan_err, 0);
    endtask

    task automatic t_fire();
        @(negedge clk); cell_ready = 4'b0100;
        @(negedge clk); cell_ready = 4'b0000;
        chk("R8 fire", fire_valid, 1); chk("R8 cell", fire_cell, 2);
        @(negedge clk); chk("R8 one", fire_valid, 0);
    endtask

    task automatic t_evict();
        send(8'h60);
        chk("R4 evict", evict_valid, 1); chk("R9 lru victim", evict_cell, 0);
        chk("R4 old minor", evict_minor, 8'h10); chk("R4 retr", retr_minor, 8'h60);
        chk("R4 upd", upd_cell, 0); chk("R4 store late", store_valid, 0);
        @(negedge clk);
        chk("R4 store", store_valid, 1); chk("R4 store minor", store_minor, 8'h10);
    endtask

    task automatic t_same_cycle();
        @(negedge clk); cell_ready = 4'b0010; pkt_valid = 1'b1; pkt_minor = 8'h70;
        @(negedge clk); cell_ready = 4'b0000; pkt_valid = 1'b0;
        chk("R10 fire", fire_valid, 1); chk("R10 fire cell", fire_cell, 1);
        chk("R10 evict", evict_valid, 1); chk("R10 victim", evict_cell, 3);
        chk("R10 old", evict_minor, 8'h40);
    endtask

    task automatic t_engaged();
        @(negedge clk); cell_ready = 4'b1001;
        @(negedge clk); cell_ready = 4'b0000;
        chk("R8 engaged no fire", fire_valid, 0);
        send(8'h60);
        chk("R2 engaged hit", upd_cell, 0); chk("R2 engaged no retr", retr_valid, 0);
    endtask

    task automatic t_exhaust();
        send(8'h80); chk("R9 victim2", evict_cell, 2); chk("R9 old30", evict_minor, 8'h30);
        send(8'h90); chk("R9 victim1", evict_cell, 1); chk("R9 old20", evict_minor, 8'h20);
        @(negedge clk); pkt_valid = 1'b1; pkt_minor = 8'hA0;
        #1 chk("R5 accept low", pkt_accept, 0);
        @(negedge clk); pkt_valid = 1'b0;
        chk("R5 no upd", upd_valid, 0); chk("R5 no retr", retr_valid, 0);
        chk("R5 no evict", evict_valid, 0);
        send_ins(8'h60); chk("R6 merge load", load_cell, 0);
        send(8'hA0); chk("R6 evictable", evict_cell, 0); chk("R6 old60", evict_minor, 8'h60);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_orphan();
        t_load();
        t_fire();
        t_evict();
        t_same_cycle();
        t_engaged();
        t_exhaust();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule